// File: doc/BRIEF.md
# PWM Trap and Modulation Output Conditioner

This block sits between a PWM compare stage and the output pins. It takes the raw PWM levels and decides, cycle by cycle, whether they reach the pins. Two separate mechanisms can hold the pins back.

A fault (trap) input latches a trap state that drives every output to a configurable safe level. Leaving that state can be automatic or left to software. It can also be delayed to the next PWM period boundary, so the waveform restarts at a clean edge.

A modulation input acts in one of two ways, chosen by configuration. It can gate the outputs to the same safe level, or it can produce a status-clear strobe for the compare stage. Its effect can likewise be sampled only at period boundaries.

Top module: `pwm_trap_modgate`

## Requirements
- R1: After reset, `trap_state` and `status_clr` are 0 and `pwm_out` equals `pwm_in`.
- R2: While `cfg_trap_en` is 0, the trap input has no effect. `trap_state` is 0 from the next clock on, and the outputs are not forced.
- R3: With `cfg_trap_en` at 1, a high `trap_in` sets `trap_state` at the next clock edge, whatever the synchronization setting. While `trap_state` is 1, `pwm_out` equals `cfg_passive`.
- R4: With `cfg_trap_swclr` at 0 and `cfg_trap_sync` at 0, `trap_state` clears at the first clock edge at which `trap_in` is sampled low.
- R5: With `cfg_trap_sync` at 1, `trap_state` can clear only at a clock edge where `period_pulse` is sampled high. In every other case the clearing rules of R4 and R6 apply.
- R6: With `cfg_trap_swclr` at 1, leaving the trap state requires a `sw_trap_clr` pulse, given while `trap_in` is low. That request is held until the exit is allowed.
- R7: A `sw_trap_clr` pulse given while `trap_in` is high is ignored. It is not remembered for later.
- R8: With `cfg_mod_type` at 1 and the effective modulation level at 1, every bit of `pwm_out` equals `cfg_passive`, and `status_clr` stays 0.
- R9: With `cfg_mod_type` at 0, the effective modulation level appears on `status_clr` and does not alter `pwm_out`.
- R10: With `cfg_mod_sync` at 0, the effective modulation level is `mod_in` as sampled at the previous clock edge. With it at 1, the level is updated from `mod_in` only at edges where `period_pulse` is high.
- R11: The safe level applies per output bit, as given by `cfg_passive`. Bit i of `pwm_out` is forced to bit i of `cfg_passive`.

Ports are listed below in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | N_OUT | Raw PWM levels from the compare stage |
| period_pulse | input | 1 | One-cycle PWM period boundary pulse |
| trap_in | input | 1 | Trap (fault) input, active high |
| mod_in | input | 1 | External modulation input, active high |
| sw_trap_clr | input | 1 | Software trap-exit request pulse |
| cfg_trap_en | input | 1 | Trap function enable |
| cfg_trap_sync | input | 1 | Trap exit aligned to period boundary |
| cfg_trap_swclr | input | 1 | Trap exit only by software request |
| cfg_mod_type | input | 1 | 0: modulation clears status, 1: modulation gates outputs |
| cfg_mod_sync | input | 1 | Modulation sampled only at period boundary |
| cfg_passive | input | N_OUT | Safe (passive) level per output |
| pwm_out | output | N_OUT | Conditioned PWM levels |
| trap_state | output | 1 | Trap state flag |
| status_clr | output | 1 | Compare status clear strobe |

## Verification
A behavioural reference model predicts all three outputs on every clock. It is run through directed phases, each of which isolates one mode.

The first phases try the trap with the function disabled and then with automatic exit. Comparing unsynchronized against period-synchronized exit separates an immediate release from one held to a boundary. The software-exit phase tries a request given during an active trap and then one given after the trap input drops. This separates an ignored request from a remembered one.

The modulation phases switch between gating and status-clear, and between free-running and boundary-sampled modulation. An input toggling off the boundary exposes any sampling error there. A final long run with mixed random stimulus and configuration covers interactions between trap and modulation.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  typedef enum logic {
    MOD_CLR_STATUS = 1'b0,
    MOD_GATE_OUT   = 1'b1
  } mod_type_e;

  typedef struct packed {
    logic trap_en;
    logic trap_sync;
    logic trap_swclr;
  } trap_cfg_t;
endpackage

// File: rtl/pwm_trap_ctrl.sv
module pwm_trap_ctrl
  import pwm_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trap_cfg_t cfg,
  input  logic      trap_in,
  input  logic      sw_clr,
  input  logic      period_pulse,
  output logic      trap_q
);
  logic trap_d;
  logic arm_q, arm_d;
  logic sw_seen, exit_ok, state_en;

  always_comb begin
    sw_seen = arm_q | sw_clr;
    exit_ok = (!cfg.trap_swclr | sw_seen) & (!cfg.trap_sync | period_pulse);
    trap_d  = 1'b0;
    arm_d   = 1'b0;
    if (!cfg.trap_en) begin
      trap_d = 1'b0;
      arm_d  = 1'b0;
    end else if (trap_in) begin
      trap_d = 1'b1;
      arm_d  = 1'b0;
    end else if (trap_q) begin
      trap_d = !exit_ok;
      arm_d  = !exit_ok & sw_seen;
    end
    state_en = (trap_d != trap_q) | (arm_d != arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (state_en) begin
      trap_q <= trap_d;
      arm_q  <= arm_d;
    end
  end

  a_r3_entry_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.trap_en && trap_in) |=> trap_q);
  a_r2_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.trap_en |=> !trap_q);
  a_r5_sync_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q && cfg.trap_en && cfg.trap_sync && !period_pulse) |=> trap_q);
  a_r7_held_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q && cfg.trap_en && trap_in && sw_clr) |=> trap_q);
  a_r6_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q && cfg.trap_en && cfg.trap_swclr && !arm_q && !sw_clr) |=> trap_q);
endmodule

// File: rtl/pwm_mod_ctrl.sv
module pwm_mod_ctrl
  import pwm_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mod_in,
  input  logic      mod_sync,
  input  mod_type_e mod_type,
  input  logic      period_pulse,
  output logic      gate,
  output logic      status_clr
);
  logic mod_q, mod_d, load_en;

  always_comb begin
    load_en = !mod_sync | period_pulse;
    mod_d   = mod_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mod_q <= 1'b0;
    else if (load_en) mod_q <= mod_d;
  end

  always_comb begin
    gate       = mod_q & (mod_type == MOD_GATE_OUT);
    status_clr = mod_q & (mod_type == MOD_CLR_STATUS);
  end

  a_r10_sync_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sync && !period_pulse) |=> $stable(mod_q));
  a_r10_free_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_sync |=> (mod_q == $past(mod_in)));
endmodule

// File: rtl/pwm_out_mux.sv
module pwm_out_mux #(
  parameter int N_OUT = 2
) (
  input  logic [N_OUT-1:0] pwm_in,
  input  logic [N_OUT-1:0] passive,
  input  logic             force_passive,
  output logic [N_OUT-1:0] pwm_out
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    always_comb pwm_out[i] = force_passive ? passive[i] : pwm_in[i];
  end
endmodule

// File: rtl/pwm_trap_modgate.sv
module pwm_trap_modgate
  import pwm_gate_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] pwm_in,
  input  logic             period_pulse,
  input  logic             trap_in,
  input  logic             mod_in,
  input  logic             sw_trap_clr,
  input  logic             cfg_trap_en,
  input  logic             cfg_trap_sync,
  input  logic             cfg_trap_swclr,
  input  logic             cfg_mod_type,
  input  logic             cfg_mod_sync,
  input  logic [N_OUT-1:0] cfg_passive,
  output logic [N_OUT-1:0] pwm_out,
  output logic             trap_state,
  output logic             status_clr
);
  trap_cfg_t tcfg;
  mod_type_e mtype;
  logic      gate;
  logic      force_passive;

  always_comb begin
    tcfg.trap_en    = cfg_trap_en;
    tcfg.trap_sync  = cfg_trap_sync;
    tcfg.trap_swclr = cfg_trap_swclr;
    mtype           = mod_type_e'(cfg_mod_type);
    force_passive   = trap_state | gate;
  end

  pwm_trap_ctrl u_trap (
    .clk(clk), .rst_n(rst_n), .cfg(tcfg), .trap_in(trap_in),
    .sw_clr(sw_trap_clr), .period_pulse(period_pulse), .trap_q(trap_state)
  );

  pwm_mod_ctrl u_mod (
    .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .mod_sync(cfg_mod_sync),
    .mod_type(mtype), .period_pulse(period_pulse), .gate(gate),
    .status_clr(status_clr)
  );

  pwm_out_mux #(.N_OUT(N_OUT)) u_mux (
    .pwm_in(pwm_in), .passive(cfg_passive), .force_passive(force_passive),
    .pwm_out(pwm_out)
  );

  a_r3_trap_passive: assert property (@(posedge clk) disable iff (!rst_n)
    trap_state |-> (pwm_out == cfg_passive));
  a_r8_gate_passive: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (pwm_out == cfg_passive && !status_clr));
  a_r9_no_alter: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_state && !cfg_mod_type) |-> (pwm_out == pwm_in));
endmodule

// File: tb/pwm_trap_modgate_tb_top.sv
module pwm_trap_modgate_tb_top;
  localparam int N = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pwm_in = '0, cfg_passive = '0;
  logic period_pulse = 0, trap_in = 0, mod_in = 0, sw_trap_clr = 0;
  logic cfg_trap_en = 0, cfg_trap_sync = 0, cfg_trap_swclr = 0;
  logic cfg_mod_type = 0, cfg_mod_sync = 0;
  logic [N-1:0] pwm_out;
  logic trap_state, status_clr;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  bit m_trap = 0, m_arm = 0, m_mod = 0;

  always #5 clk = ~clk;

  pwm_trap_modgate #(.N_OUT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_pulse(period_pulse),
    .trap_in(trap_in), .mod_in(mod_in), .sw_trap_clr(sw_trap_clr),
    .cfg_trap_en(cfg_trap_en), .cfg_trap_sync(cfg_trap_sync),
    .cfg_trap_swclr(cfg_trap_swclr), .cfg_mod_type(cfg_mod_type),
    .cfg_mod_sync(cfg_mod_sync), .cfg_passive(cfg_passive),
    .pwm_out(pwm_out), .trap_state(trap_state), .status_clr(status_clr)
  );

  // Reference model: behavioural next-state per requirement
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_trap = 0; m_arm = 0; m_mod = 0;
    end else begin
      bit req, boundary_ok, leave;
      req = m_arm || sw_trap_clr;
      boundary_ok = !cfg_trap_sync || period_pulse;
      leave = (!cfg_trap_swclr || req) && boundary_ok;
      if (!cfg_trap_en) begin m_trap = 0; m_arm = 0; end    // R2
      else if (trap_in) begin m_trap = 1; m_arm = 0; end    // R3, R7
      else if (m_trap) begin                                // R4, R5, R6
        if (leave) begin m_trap = 0; m_arm = 0; end
        else m_arm = req;
      end
      if (!cfg_mod_sync || period_pulse) m_mod = mod_in;    // R10
    end
  end

  task automatic check();
    logic [N-1:0] e_out;
    bit e_clr;
    e_out = (m_trap || (m_mod && cfg_mod_type)) ? cfg_passive : pwm_in;  // R8, R11
    e_clr = m_mod && !cfg_mod_type;                                       // R9
    checks++;
    if (pwm_out !== e_out || trap_state !== m_trap || status_clr !== e_clr) begin
      failures++;
      $display("FAIL %s cyc=%0d actual out=%b trap=%b clr=%b expected out=%b trap=%b clr=%b",
               tag, cyc, pwm_out, trap_state, status_clr, e_out, m_trap, e_clr);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      check();
      period_pulse = 0;
      sw_trap_clr = 0;
      pwm_in = pwm_in + 1'b1;
    end
  endtask

  task automatic pulse_period();
    period_pulse = 1;
    tick();
  endtask

  initial begin
    tag = "R1";
    cfg_passive = 2'b01;
    #1 check();
    tick(2);
    rst_n = 1;
    tick(2);

    tag = "R2";
    trap_in = 1; tick(4); trap_in = 0; tick(2);

    tag = "R3";
    cfg_trap_en = 1; cfg_trap_sync = 1; trap_in = 1; tick(3);

    tag = "R5";
    trap_in = 0; tick(3); pulse_period(); tick(2);

    tag = "R4";
    cfg_trap_sync = 0; trap_in = 1; tick(2); trap_in = 0; tick(3);

    tag = "R7";
    cfg_trap_swclr = 1; trap_in = 1; tick(2); sw_trap_clr = 1; tick(1);
    trap_in = 0; tick(4);

    tag = "R6";
    sw_trap_clr = 1; tick(2);
    cfg_trap_sync = 1; trap_in = 1; tick(1); trap_in = 0; tick(1);
    sw_trap_clr = 1; tick(3); pulse_period(); tick(2);

    tag = "R11";
    cfg_passive = 2'b10; trap_in = 1; tick(3); cfg_passive = 2'b11; tick(2);
    trap_in = 0; sw_trap_clr = 1; period_pulse = 1; tick(2);
    cfg_trap_swclr = 0; cfg_trap_sync = 0;

    tag = "R8";
    cfg_mod_type = 1; cfg_passive = 2'b01; mod_in = 1; tick(3); mod_in = 0; tick(2);

    tag = "R9";
    cfg_mod_type = 0; mod_in = 1; tick(3); mod_in = 0; tick(2);

    tag = "R10";
    cfg_mod_sync = 1; mod_in = 1; tick(3); pulse_period(); tick(2);
    mod_in = 0; tick(2); pulse_period(); tick(2);
    cfg_mod_type = 1; mod_in = 1; pulse_period(); tick(3);

    tag = "R12";
    for (int k = 0; k < 3000; k++) begin
      trap_in = ($urandom_range(0, 9) == 0);
      mod_in = $urandom_range(0, 1);
      sw_trap_clr = ($urandom_range(0, 5) == 0);
      period_pulse = ($urandom_range(0, 7) == 0);
      pwm_in = N'($urandom);
      if ((k % 200) == 0) begin
        {cfg_trap_en, cfg_trap_sync, cfg_trap_swclr, cfg_mod_type, cfg_mod_sync} = 5'($urandom);
        cfg_passive = N'($urandom);
      end
      @(negedge clk);
      cyc++;
      check();
    end
    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule